// File: doc/BRIEF.md
# Serial Byte Transmitter with Gated Bit Clock

This block turns bytes written on a parallel strobe interface into asynchronous serial frames on a single output line. It runs from a clock at eight times the bit rate (the oversampling ratio is a parameter). Each frame holds one low start bit and eight data bits, least significant first. An optional parity bit (even or odd) follows, then one high stop bit. Between frames the line rests high.

A one-byte holding stage sits in front of the shift engine, so software or a feeding block can queue the next byte while the current frame is still going out. When a byte is pending as a stop bit ends, the next start bit follows with no idle time. Two flags report progress. One shows that the holding stage is free. The other shows that the line went quiet with nothing left to send.

Alongside the line, the block drives a bit clock for an external checker such as a CRC engine. This clock runs at one eighth of the input clock and toggles only during data bits. Its rising edge lands in the middle of each data bit, where the line is stable. It stays high during the start, parity and stop bits and while idle.

Top module: `uart_bitclk_tx`

## Requirements
- R1: After reset, `txd` is 1, `bit_clk` is 1, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame is a start bit at 0, then the 8 data bits least significant bit first, then a stop bit at 1. Each bit holds its level on `txd` for exactly OVS (default 8) clock cycles.
- R3: `par_sel` selects the parity mode: 0 = none, 1 = even, 2 = odd, 3 = none. With even parity, a parity bit sits between the last data bit and the stop bit, and the ones in data plus parity make an even count. With odd parity the count is odd.
- R4: With parity disabled, the stop bit comes directly after the eighth data bit.
- R5: The parity mode is captured with the byte on the write cycle. Later changes to `par_sel` do not affect that byte's frame.
- R6: During each data bit, `bit_clk` is 0 for the first OVS/2 cycles and 1 for the rest. Its rising edge therefore falls in the middle of the data bit.
- R7: `bit_clk` is 1 during start, parity and stop bits and while idle.
- R8: A write with `wr_en`=1 while `buf_empty`=1 drives `buf_empty` to 0 from the next cycle. `buf_empty` returns to 1 in the cycle the byte moves into the shifter. That is one cycle later when the line is idle.
- R9: A write while `buf_empty` is 0 is ignored. The pending byte is kept, and no extra frame is sent.
- R10: If a byte is pending when a stop bit ends, its start bit begins on the very next cycle, with no idle cycle.
- R11: `tx_done` rises when a stop bit ends with no byte pending. It is 0 from the first cycle of the next start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at OVS times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to transmit |
| par_sel | input | 2 | Parity mode, captured with the byte |
| txd | output | 1 | Serial line output, idles high |
| bit_clk | output | 1 | Gated bit clock, toggles only during data bits |
| buf_empty | output | 1 | Holding stage is free to accept a byte |
| tx_done | output | 1 | Line idle with no pending byte after a frame |

## Verification
The hardest condition to reach from the ports is the boundary between two frames: a pending byte must start on the cycle right after the stop bit, and a write that arrives while the holding stage is full must be dropped. The stimulus writes a second byte as soon as `buf_empty` rises during a frame. It then strobes a third byte while the stage is still full. The monitor, acting as a receiver, timestamps the next start bit against the previous stop bit. Any extra frame pops an empty expectation queue and is reported. Each write also flips `par_sel` right after the strobe, so parity capture is checked on every frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE     = 2'd0,
    PAR_EVEN     = 2'd1,
    PAR_ODD      = 2'd2,
    PAR_NONE_ALT = 2'd3
  } par_mode_e;

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  par_mode_e         wr_mode,
  input  logic              take,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output par_mode_e         mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      mode  <= PAR_NONE;
    end else begin
      if (wr_en && !valid) begin
        valid <= 1'b1;
        data  <= wr_data;
        mode  <= wr_mode;
      end else if (take) begin
        valid <= 1'b0;
      end
    end
  end

  // R9: a write into a full stage leaves the pending byte untouched
  a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && valid && !take) |=> (valid && $stable(data) && $stable(mode)));

endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 8,
  localparam int CW    = (OVS > 1) ? $clog2(OVS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  par_mode_e         hold_mode,
  output logic              take,
  output logic              txd,
  output tx_state_e         state_q,
  output tx_state_e         state_n,
  output logic [CW-1:0]     cnt_q,
  output logic [CW-1:0]     cnt_n,
  output logic              done
);

  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     idx;
  logic              par_en;
  logic              par_bit;
  logic              last;
  logic              txd_n;

  assign last = (cnt_q == LAST_TICK);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q + 1'b1;
    take    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_n = '0;
        if (hold_valid) begin
          take    = 1'b1;
          state_n = ST_START;
        end
      end
      ST_START: begin
        if (last) begin
          state_n = ST_DATA;
          cnt_n   = '0;
        end
      end
      ST_DATA: begin
        if (last) begin
          cnt_n = '0;
          if (idx == LAST_BIT) state_n = par_en ? ST_PARITY : ST_STOP;
        end
      end
      ST_PARITY: begin
        if (last) begin
          state_n = ST_STOP;
          cnt_n   = '0;
        end
      end
      ST_STOP: begin
        if (last) begin
          cnt_n = '0;
          if (hold_valid) begin
            take    = 1'b1;
            state_n = ST_START;
          end else begin
            state_n = ST_IDLE;
          end
        end
      end
      default: begin
        state_n = ST_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_comb begin
    unique case (state_n)
      ST_START:  txd_n = 1'b0;
      ST_DATA: begin
        if (state_q != ST_DATA) txd_n = shreg[0];
        else if (last)          txd_n = (DATA_W > 1) ? shreg[1] : shreg[0];
        else                    txd_n = txd;
      end
      ST_PARITY: txd_n = par_bit;
      default:   txd_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg   <= '0;
      idx     <= '0;
      par_en  <= 1'b0;
      par_bit <= 1'b0;
      txd     <= 1'b1;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      txd     <= txd_n;
      if (take) begin
        shreg   <= hold_data;
        idx     <= '0;
        par_en  <= (hold_mode == PAR_EVEN) || (hold_mode == PAR_ODD);
        par_bit <= (hold_mode == PAR_ODD) ? ~(^hold_data) : (^hold_data);
        done    <= 1'b0;
      end else begin
        if (state_q == ST_DATA && last) begin
          shreg <= shreg >> 1;
          idx   <= idx + 1'b1;
        end
        if (state_q == ST_STOP && last) done <= 1'b1;
      end
    end
  end

  // R10: a pending byte starts right after the stop bit
  a_r10_no_idle_gap: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP && last && hold_valid) |=> (state_q == ST_START && cnt_q == '0));

  // R4: without parity, no parity slot is ever entered
  a_r4_skip_parity: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PARITY) |-> par_en);

endmodule

// File: rtl/tx_bitclk_gen.sv
module tx_bitclk_gen
  import uart_tx_pkg::*;
#(
  parameter int OVS   = 8,
  localparam int CW   = (OVS > 1) ? $clog2(OVS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  tx_state_e     state_n,
  input  logic [CW-1:0] cnt_n,
  output logic          bit_clk
);

  localparam logic [CW-1:0] HALF = CW'(OVS / 2);

  always_ff @(posedge clk) begin
    if (rst) bit_clk <= 1'b1;
    else     bit_clk <= !((state_n == ST_DATA) && (cnt_n < HALF));
  end

endmodule

// File: rtl/uart_bitclk_tx.sv
module uart_bitclk_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        par_sel,
  output logic              txd,
  output logic              bit_clk,
  output logic              buf_empty,
  output logic              tx_done
);

  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] HALF = CW'(OVS / 2);

  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  par_mode_e         hold_mode;
  logic              take;
  tx_state_e         state_q, state_n;
  logic [CW-1:0]     cnt_q, cnt_n;

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_mode (par_mode_e'(par_sel)),
    .take    (take),
    .valid   (hold_valid),
    .data    (hold_data),
    .mode    (hold_mode)
  );

  tx_frame_engine #(.DATA_W(DATA_W), .OVS(OVS)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .hold_mode  (hold_mode),
    .take       (take),
    .txd        (txd),
    .state_q    (state_q),
    .state_n    (state_n),
    .cnt_q      (cnt_q),
    .cnt_n      (cnt_n),
    .done       (tx_done)
  );

  tx_bitclk_gen #(.OVS(OVS)) u_bclk (
    .clk     (clk),
    .rst     (rst),
    .state_n (state_n),
    .cnt_n   (cnt_n),
    .bit_clk (bit_clk)
  );

  assign buf_empty = !hold_valid;

  // R1 / R2: idle line rests high
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> txd);

  // R2: start bit drives the line low
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START) |-> !txd);

  // R6: bit clock rises only at mid data bit
  a_r6_rise_midbit: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_clk) |-> (state_q == ST_DATA && cnt_q == HALF));

  // R7: bit clock held high outside data bits
  a_r7_bitclk_high_outside: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_DATA) |-> bit_clk);

  // R11: done flag clears only when a new frame starts
  a_r11_done_fall_on_start: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_done) |-> (state_q == ST_START && cnt_q == '0));

endmodule

// File: tb/sim_uart_bitclk_tx.sv
`timescale 1ns/1ps
module sim_uart_bitclk_tx;

  localparam int OVS = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] par_sel = 2'd0;
  logic       txd, bit_clk, buf_empty, tx_done;

  int checks = 0;
  int fails  = 0;
  int frames_sent = 0;
  int frames_seen = 0;
  int b2b_count = 0;
  bit finished = 1'b0;
  logic [9:0] exp_q[$];

  always #4 clk = ~clk;

  uart_bitclk_tx #(.DATA_W(8), .OVS(OVS)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .par_sel(par_sel),
    .txd(txd), .bit_clk(bit_clk), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: wait for free stage, strobe one byte, push expectation, disturb par_sel
  task automatic send(input logic [7:0] d, input logic [1:0] m);
    @(negedge clk);
    while (!buf_empty) @(negedge clk);
    wr_en = 1'b1; wr_data = d; par_sel = m;
    exp_q.push_back({m, d});
    frames_sent++;
    @(negedge clk);
    wr_en = 1'b0;
    par_sel = m ^ 2'b11; // R5: later mode changes must not matter
  endtask

  task automatic wait_quiet();
    while (frames_seen < frames_sent) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // monitor: receive each frame and compare against the queue
  initial begin : monitor
    bit in_frame;
    logic [9:0] e;
    logic [7:0] d;
    logic [1:0] m;
    bit pen;
    logic pb;
    in_frame = 1'b0;
    forever begin
      if (!in_frame) begin
        @(negedge clk);
        while (rst || txd) @(negedge clk);
      end
      // now at first cycle of a start bit
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected frame", 1, 0);
        e = '0;
      end else begin
        e = exp_q.pop_front();
      end
      d = e[7:0]; m = e[9:8];
      pen = (m == 2'd1) || (m == 2'd2);
      pb = (m == 2'd2) ? ~(^d) : (^d);
      for (int s = 0; s < 11; s++) begin
        logic exp_bit;
        bit is_data;
        if (s == 9 && !pen) continue;
        is_data = (s >= 1 && s <= 8);
        exp_bit = (s == 0) ? 1'b0 : is_data ? d[s-1] : (s == 9) ? pb : 1'b1;
        @(negedge clk);
        chk(bit_clk == !is_data, is_data ? "R6 bit_clk low first half" : "R7 bit_clk high",
            int'(bit_clk), int'(!is_data));
        repeat (OVS/2 - 1) @(negedge clk);
        if (s == 0) chk(tx_done == 1'b0, "R11 done low in frame", int'(tx_done), 0);
        chk(txd == exp_bit,
            (s == 9) ? "R3 parity bit" : (s == 10 && !pen) ? "R4 stop after d7" : "R2 frame bit",
            int'(txd), int'(exp_bit));
        chk(bit_clk == 1'b1, "R6 bit_clk high mid bit", int'(bit_clk), 1);
        if (s != 10) repeat (OVS/2) @(negedge clk);
      end
      frames_seen++;
      repeat (OVS/2) @(negedge clk);
      if (txd == 1'b0) begin
        b2b_count++;
        in_frame = 1'b1;
      end else begin
        chk(tx_done == 1'b1, "R11 done after stop", int'(tx_done), 1);
        in_frame = 1'b0;
      end
    end
  end

  initial begin : stimulus
    int b2b_before;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(bit_clk == 1'b1, "R1 bit_clk", int'(bit_clk), 1);
    chk(buf_empty == 1'b1, "R1 buf_empty", int'(buf_empty), 1);
    chk(tx_done == 1'b0, "R1 tx_done", int'(tx_done), 0);

    // R8: write into idle block
    wr_en = 1'b1; wr_data = 8'hA5; par_sel = 2'd0;
    exp_q.push_back({2'd0, 8'hA5}); frames_sent++;
    @(negedge clk);
    wr_en = 1'b0;
    chk(buf_empty == 1'b0, "R8 buf_empty after write", int'(buf_empty), 0);
    @(negedge clk);
    chk(buf_empty == 1'b1, "R8 buf_empty after load", int'(buf_empty), 1);
    wait_quiet();

    // R3 / R4 / R5: modes and patterns
    send(8'h3C, 2'd1); wait_quiet();
    send(8'h01, 2'd2); wait_quiet();
    send(8'hFF, 2'd1); wait_quiet();
    send(8'h00, 2'd2); wait_quiet();
    send(8'h80, 2'd3); wait_quiet();
    send(8'h5A, 2'd0); wait_quiet();

    // R10 / R9: back-to-back with a write into a full stage
    b2b_before = b2b_count;
    send(8'hC3, 2'd1);
    send(8'h96, 2'd2);
    @(negedge clk);
    chk(buf_empty == 1'b0, "R9 stage full", int'(buf_empty), 0);
    wr_en = 1'b1; wr_data = 8'h77; par_sel = 2'd0;
    @(negedge clk);
    wr_en = 1'b0;
    chk(buf_empty == 1'b0, "R9 still full after ignored write", int'(buf_empty), 0);
    wait_quiet();
    chk(b2b_count == b2b_before + 1, "R10 back-to-back start", b2b_count, b2b_before + 1);
    repeat (200) @(negedge clk);
    chk(frames_seen == frames_sent, "R9 no extra frame", frames_seen, frames_sent);
    chk(tx_done == 1'b1 && txd == 1'b1, "R11 idle done", int'(tx_done), 1);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule